// File: doc/BRIEF.md
# One-Wire ROM Search Accelerator

This block walks a one-wire ROM search tree four bit positions at a time, so that the host does not have to run three bus slots for each bit. While the search-mode control bit is set, each byte the host places in the transmit buffer starts one pass over four positions. For each position the block asks the master's bus-slot engine for two read slots: the ID bit, then its complement. It picks a branch and asks for one write slot that sends the chosen bit. When all four positions are done, it loads a response byte into the receive buffer and raises the buffer-full flag.

Before entering the mode, the host resets the bus and sends the search command byte. It then sets the search-mode bit and exchanges sixteen bytes to cover a 64-bit ROM ID, lowest nibble first. It leaves the mode by clearing the bit and resetting the bus. In each transmit byte, odd bit 2k+1 gives the branch to take at position k when the devices disagree. In each response byte, odd bit 2k+1 holds the chosen ROM bit of position k and even bit 2k holds its discrepancy flag. The branch-choice algorithm that runs across passes lives in host software.

Top module: `owsra_top`

## Requirements
- R1: After reset, `busy`, `rx_full` and `slot_start` are 0 and `rx_byte` is 0x00.
- R2: A `tx_wr` pulse starts a pass only while `search_en` is 1 and `busy` is 0. With `search_en` low, the pulse causes no slot request and leaves `busy` at 0.
- R3: A pass issues exactly 12 slot requests in the order read, read, write for each of its 4 positions. `slot_start` is a one-cycle pulse, and the next request follows the `slot_done` of the previous one.
- R4: When the two reads of position k differ, the write slot sends the first read (the ID bit) and the discrepancy flag of k is 0.
- R5: When both reads of position k are 0, the discrepancy flag of k is 1 and the write slot sends bit 2k+1 of the transmit byte.
- R6: When both reads of position k are 1, the discrepancy flag of k is 1 and the write slot sends 1.
- R7: Response layout: bit 2k+1 of `rx_byte` is the bit written for position k and bit 2k is its flag. Position 0 is the first position on the bus.
- R8: `rx_full` rises in the cycle after the `slot_done` of the fourth write slot, and `rx_byte` changes only then. `rx_rd` clears `rx_full`. If `rx_rd` comes in the same cycle as that completion, `rx_full` stays set.
- R9: A `tx_wr` arriving while a pass is in progress is ignored, and the pass completes with the response of the original byte.
- R10: When `search_en` falls during a pass, `busy` is 0 one cycle later and no further slot is requested. `rx_full` and `rx_byte` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| search_en | input | 1 | Search-mode control bit |
| tx_wr | input | 1 | Host wrote the transmit byte |
| tx_byte | input | 8 | Branch directions in the odd bits |
| rx_rd | input | 1 | Host read the response byte |
| rx_full | output | 1 | Response byte waiting |
| rx_byte | output | 8 | Chosen bits (odd) and flags (even) |
| busy | output | 1 | Pass in progress |
| slot_start | output | 1 | One-cycle request for a bus slot |
| slot_wr | output | 1 | 1 for a write slot, 0 for a read slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_done | input | 1 | Slot engine finished the current slot |
| slot_rdbit | input | 1 | Bit sampled by a read slot, valid with `slot_done` |

## Verification
Two events can fall in the same clock: completion of the fourth write slot, which sets the buffer-full flag, and a host read, which clears it. The bench's slot-engine model raises `rx_rd` in the same edge on which it reports `slot_done` for that slot, while the flag is still set from the previous pass. It then checks that the flag stays high and that the byte holds the new response. A second pulse of `rx_rd` must then clear the flag.

// File: rtl/owsra_pkg.sv
package owsra_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ID   = 2'd1,
        S_CMP  = 2'd2,
        S_WR   = 2'd3
    } owsra_state_e;

endpackage

// File: rtl/owsra_pick.sv
// Branch decision for one search position from its two read slots.
module owsra_pick (
    input  logic id_bit,
    input  logic cmp_bit,
    input  logic dir_bit,
    output logic pick,
    output logic flag
);
    always_comb begin
        if (id_bit != cmp_bit) begin
            pick = id_bit;     // single answer from the devices
            flag = 1'b0;
        end else if (!id_bit) begin
            pick = dir_bit;    // conflict: host chooses
            flag = 1'b1;
        end else begin
            pick = 1'b1;       // nobody answered
            flag = 1'b1;
        end
    end
endmodule

// File: rtl/owsra_pack.sv
// Inserts one position's chosen bit and flag into the response word.
module owsra_pack #(
    parameter int NPOS = 4,
    localparam int PW  = (NPOS > 1) ? $clog2(NPOS) : 1,
    localparam int BW  = 2 * NPOS
) (
    input  logic [BW-1:0] resp_in,
    input  logic [PW-1:0] pos,
    input  logic          pick,
    input  logic          flag,
    output logic [BW-1:0] resp_out
);
    for (genvar k = 0; k < NPOS; k++) begin : g_slot
        assign resp_out[2*k+1] = (pos == PW'(k)) ? pick : resp_in[2*k+1];
        assign resp_out[2*k]   = (pos == PW'(k)) ? flag : resp_in[2*k];
    end
endmodule

// File: rtl/owsra_top.sv
module owsra_top #(
    parameter int NPOS = 4,
    localparam int PW  = (NPOS > 1) ? $clog2(NPOS) : 1,
    localparam int BW  = 2 * NPOS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          search_en,
    input  logic          tx_wr,
    input  logic [BW-1:0] tx_byte,
    input  logic          rx_rd,
    output logic          rx_full,
    output logic [BW-1:0] rx_byte,
    output logic          busy,
    output logic          slot_start,
    output logic          slot_wr,
    output logic          slot_wbit,
    input  logic          slot_done,
    input  logic          slot_rdbit
);
    import owsra_pkg::*;

    localparam logic [PW-1:0] LAST = PW'(NPOS - 1);

    typedef struct packed {
        owsra_state_e  st;
        logic [PW-1:0] pos;
        logic          idb;
        logic          pick;
        logic          flag;
        logic [BW-1:0] dir;
        logic [BW-1:0] resp;
        logic [BW-1:0] rxb;
        logic          full;
        logic          start;
    } regs_t;

    regs_t q, d;

    logic          dir_bit;
    logic          pick_w;
    logic          flag_w;
    logic [BW-1:0] packed_w;
    logic          done_ok;

    // direction bit for the current position: odd bit 2*pos+1
    always_comb begin
        dir_bit = 1'b0;
        for (int k = 0; k < NPOS; k++) begin
            if (q.pos == PW'(k)) dir_bit = q.dir[2*k+1];
        end
    end

    owsra_pick pick_i (
        .id_bit  (q.idb),
        .cmp_bit (slot_rdbit),
        .dir_bit (dir_bit),
        .pick    (pick_w),
        .flag    (flag_w)
    );

    owsra_pack #(.NPOS(NPOS)) pack_i (
        .resp_in  (q.resp),
        .pos      (q.pos),
        .pick     (q.pick),
        .flag     (q.flag),
        .resp_out (packed_w)
    );

    // a completion is never taken in the cycle a request goes out
    assign done_ok = slot_done && !q.start;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (rx_rd) d.full = 1'b0;
        if (!search_en) begin
            d.st = S_IDLE;
        end else begin
            unique case (q.st)
                S_IDLE: if (tx_wr) begin
                    d.dir   = tx_byte;
                    d.pos   = '0;
                    d.resp  = '0;
                    d.st    = S_ID;
                    d.start = 1'b1;
                end
                S_ID: if (done_ok) begin
                    d.idb   = slot_rdbit;
                    d.st    = S_CMP;
                    d.start = 1'b1;
                end
                S_CMP: if (done_ok) begin
                    d.pick  = pick_w;
                    d.flag  = flag_w;
                    d.st    = S_WR;
                    d.start = 1'b1;
                end
                S_WR: if (done_ok) begin
                    d.resp = packed_w;
                    if (q.pos == LAST) begin
                        d.st   = S_IDLE;
                        d.rxb  = packed_w;
                        d.full = 1'b1;   // set wins over a same-cycle read
                    end else begin
                        d.pos   = q.pos + 1'b1;
                        d.st    = S_ID;
                        d.start = 1'b1;
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_full    = q.full;
    assign rx_byte    = q.rxb;
    assign busy       = (q.st != S_IDLE);
    assign slot_start = q.start;
    assign slot_wr    = (q.st == S_WR);
    assign slot_wbit  = q.pick;

endmodule

// File: rtl/owsra_chk.sv
module owsra_chk #(
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          search_en,
    input logic          rx_rd,
    input logic          rx_full,
    input logic [BW-1:0] rx_byte,
    input logic          busy,
    input logic          slot_start,
    input logic          slot_wr,
    input logic          slot_wbit,
    input logic          slot_done,
    input logic          slot_rdbit
);
    // the two most recent read-slot results (rd_a older)
    logic rd_a, rd_b;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_a <= 1'b0;
            rd_b <= 1'b0;
        end else if (slot_done && !slot_wr) begin
            rd_a <= rd_b;
            rd_b <= slot_rdbit;
        end
    end

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |=> !slot_start);

    p_diff_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && slot_wr && (rd_a != rd_b)) |-> (slot_wbit == rd_a));

    p_void_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && slot_wr && rd_a && rd_b) |-> slot_wbit);

    p_full_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(slot_done && slot_wr));

    p_rxbyte_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> $past(slot_done && slot_wr));

    p_exit_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !search_en |=> (!busy && !slot_start));

endmodule

bind owsra_top owsra_chk #(.BW(BW)) chk_i (.*);

// File: tb/owsra_top_tb_top.sv
`timescale 1ns/1ps
module owsra_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       search_en = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       rx_rd_host = 1'b0;
    logic       rx_rd_auto;
    logic       rx_rd;
    logic       rx_full, busy, slot_start, slot_wr, slot_wbit;
    logic [7:0] rx_byte;
    logic       slot_done, slot_rdbit;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    assign rx_rd = rx_rd_host | rx_rd_auto;

    owsra_top dut_i (
        .clk(clk), .rst_n(rst_n), .search_en(search_en), .tx_wr(tx_wr),
        .tx_byte(tx_byte), .rx_rd(rx_rd), .rx_full(rx_full), .rx_byte(rx_byte),
        .busy(busy), .slot_start(slot_start), .slot_wr(slot_wr),
        .slot_wbit(slot_wbit), .slot_done(slot_done), .slot_rdbit(slot_rdbit)
    );

    // ---- slot-engine model: answers each request three cycles later ----
    logic [7:0] rd_script = 8'h00;  // reads of one pass: [2k]=id, [2k+1]=complement
    logic       rd_on_done = 1'b0;  // pulse rx_rd with the last write completion
    logic [3:0] wr_log;
    logic [2:0] rd_idx;
    logic [1:0] wr_idx;
    logic [1:0] cnt;
    logic       kind_wr, wbit_lat;
    int         n_starts;
    string      order_log;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_done <= 1'b0; slot_rdbit <= 1'b0; rx_rd_auto <= 1'b0;
            wr_log <= 4'h0; rd_idx <= 3'd0; wr_idx <= 2'd0; cnt <= 2'd0;
            kind_wr <= 1'b0; wbit_lat <= 1'b0; n_starts <= 0; order_log <= "";
        end else begin
            slot_done  <= 1'b0;
            rx_rd_auto <= 1'b0;
            if (cnt != 2'd0) begin
                cnt <= cnt - 2'd1;
                if (cnt == 2'd1) begin
                    slot_done <= 1'b1;
                    if (!kind_wr) begin
                        slot_rdbit <= rd_script[rd_idx];
                        rd_idx     <= rd_idx + 3'd1;
                    end else begin
                        wr_log[wr_idx] <= wbit_lat;
                        wr_idx         <= wr_idx + 2'd1;
                        if (rd_on_done && wr_idx == 2'd3) rx_rd_auto <= 1'b1;
                    end
                end
            end
            if (slot_start) begin
                cnt       <= 2'd3;
                kind_wr   <= slot_wr;
                wbit_lat  <= slot_wbit;
                n_starts  <= n_starts + 1;
                order_log <= {order_log, slot_wr ? "W" : "R"};
            end
        end
    end

    // ---- checking helpers ----
    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic load_script(input logic [3:0] idv, input logic [3:0] cmpv);
        for (int k = 0; k < 4; k++) begin
            rd_script[2*k]   = idv[k];
            rd_script[2*k+1] = cmpv[k];
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        tx_byte = b;
        tx_wr   = 1'b1;
        @(negedge clk);
        tx_wr   = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic host_read();
        @(negedge clk);
        rx_rd_host = 1'b1;
        @(negedge clk);
        rx_rd_host = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // ---- stimulus table: odd bits of tx give branch directions ----
    typedef struct packed {
        logic [7:0] tx;
        logic [3:0] idv;
        logic [3:0] cmpv;
        logic [7:0] exp;
        logic [3:0] expw;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h00, 4'b0101, 4'b1010, 8'h22, 4'b0101},  // all differ (R4)
        '{8'hAA, 4'b0000, 4'b0000, 8'hFF, 4'b1111},  // conflicts, host picks 1 (R5)
        '{8'h00, 4'b0000, 4'b0000, 8'h55, 4'b0000},  // conflicts, host picks 0 (R5)
        '{8'h00, 4'b1111, 4'b1111, 8'hFF, 4'b1111},  // no device (R6)
        '{8'h08, 4'b0101, 4'b1100, 8'h3E, 4'b0111},  // mixed (R7)
        '{8'h80, 4'b0000, 4'b0000, 8'hD5, 4'b1000}   // only top direction set (R5)
    };

    initial begin
        #500000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(!busy && !rx_full && !slot_start, "R1 idle flags",
              {busy, rx_full, slot_start}, 0);
        check(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 8'h00);

        // R2 write ignored outside search mode
        s0 = n_starts;
        send(8'hAA);
        repeat (20) @(negedge clk);
        check(n_starts == s0 && !busy, "R2 ignored without mode",
              n_starts - s0, 0);

        search_en = 1'b1;
        @(negedge clk);

        // table walk
        foreach (VECS[i]) begin
            load_script(VECS[i].idv, VECS[i].cmpv);
            s0 = n_starts;
            order_log = "";
            send(VECS[i].tx);
            wait_idle();
            check(rx_full, "R8 full after pass", rx_full, 1);
            check(rx_byte == VECS[i].exp, "R7 response byte", rx_byte, VECS[i].exp);
            check(wr_log == VECS[i].expw, "R4/R5/R6 write bits", wr_log, VECS[i].expw);
            check(n_starts - s0 == 12, "R3 slot count", n_starts - s0, 12);
            check(order_log == "RRWRRWRRWRRW", "R3 slot order", 0, 0);
            host_read();
            check(!rx_full, "R8 read clears full", rx_full, 0);
        end

        // R9 second write during a pass is ignored
        load_script(4'b0000, 4'b0000);
        s0 = n_starts;
        send(8'h00);
        repeat (6) @(negedge clk);
        send(8'hAA);
        wait_idle();
        check(rx_byte == 8'h55, "R9 busy write ignored", rx_byte, 8'h55);
        check(n_starts - s0 == 12, "R9 no extra slots", n_starts - s0, 12);
        repeat (20) @(negedge clk);
        check(n_starts - s0 == 12 && !busy, "R9 no second pass", n_starts - s0, 12);

        // R8 completion and host read in the same cycle: full is still set
        load_script(4'b1111, 4'b1111);
        rd_on_done = 1'b1;
        send(8'h00);
        wait_idle();
        rd_on_done = 1'b0;
        check(rx_full, "R8 set wins over read", rx_full, 1);
        check(rx_byte == 8'hFF, "R8 new byte on tie", rx_byte, 8'hFF);
        host_read();
        check(!rx_full, "R8 later read clears", rx_full, 0);

        // R10 leaving search mode mid-pass
        load_script(4'b0101, 4'b1010);
        send(8'h00);
        repeat (8) @(negedge clk);
        search_en = 1'b0;
        @(negedge clk);
        check(!busy, "R10 idle after exit", busy, 0);
        s0 = n_starts;
        repeat (30) @(negedge clk);
        check(n_starts == s0, "R10 no further slots", n_starts - s0, 0);
        check(!rx_full && rx_byte == 8'hFF, "R10 buffer kept",
              {rx_full, rx_byte}, 9'h0FF);

        do_reset();
        check(!busy && !rx_full && rx_byte == 8'h00, "R1 after second reset",
              {busy, rx_full, rx_byte}, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule